// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block runs the transmit half of a descriptor-ring DMA. Software builds a chain of four-word descriptors in memory, loads the address of the first one into the engine and issues a poll demand. The engine reads the descriptor at its current address. If the descriptor is marked as owned by the engine, the engine reads its buffer through a simple memory port and streams the bytes to a downstream consumer on a valid/ready byte interface. It then writes a completion status word back over the first descriptor word and follows the link word to the next descriptor.

Memory reads are combinational: the engine drives `mem_addr` with `mem_rd` high, and `mem_rdata` returns that word in the same cycle. One status write per descriptor uses the same address bus with `mem_we` high. A descriptor that the engine does not own ends the walk quietly. A malformed descriptor, or an abort or underflow signalled by the environment during streaming, ends it with an error. The engine then turns its transmit-enable flag off and waits for software, which may point it elsewhere before polling again.

Top module: `txd_engine`

## Requirements
- R1: After reset, `tx_on` is 0, `cur_addr` is 0, and `tx_valid`, `mem_rd`, `mem_we`, `done_irq` and `err_irq` are all 0.
- R2: The status word (descriptor offset +0) is read first. If bit 31 (engine owns it) is clear, the engine goes idle with no status write and no error pulse, and `tx_on` stays 1.
- R3: The control word is at offset +4 and holds the byte count in bits 10:0, start-of-packet in bit 21 and end-of-packet in bit 22. The buffer byte address is at offset +8 and the link word at offset +12.
- R4: Buffer bytes leave in ascending address order starting at the buffer address, which may be unaligned. A byte at address a is lane a[1:0] of the little-endian word at a with bits 1:0 cleared. One byte moves per cycle while `tx_ready` is 1. While `tx_ready` is 0, `tx_data` holds. `tx_last` is 1 exactly on the final byte of the count.
- R5: Every processed descriptor gets one status write at its own address. The written word has bit 31 cleared, bit 8 set on abort, bit 11 set on underflow, bit 12 set for a malformed descriptor, and all other bits 0.
- R6: After an error-free write, the next descriptor address is the link word with bit 0 cleared. `done_irq` pulses in the write cycle unless link bit 0 is 1.
- R7: A descriptor with a byte count of 0, or without both start and end bits, moves no bytes and is written back with bit 12.
- R8: If `inj_abort` or `inj_underflow` is 1 in a streaming cycle, streaming ends after that cycle. A byte handshaken in that same cycle still counts.
- R9: After any error write, `err_irq` pulses in the write cycle, `tx_on` drops to 0 and `cur_addr` stays on the failing descriptor.
- R10: A `poll_demand` in an idle cycle sets `tx_on` and starts fetching at `cur_addr`. This includes a descriptor that earlier failed.
- R11: A `cur_addr_we` write is taken only while the engine is idle. A write during a walk has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_demand | input | 1 | Start or restart fetching (idle only) |
| cur_addr_we | input | 1 | Write current-descriptor address (idle only) |
| cur_addr_wdata | input | AW | New current-descriptor address |
| cur_addr | output | AW | Current-descriptor address |
| tx_on | output | 1 | Transmit process enabled |
| mem_rd | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe (status write-back) |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | 32 | Status word written back |
| mem_rdata | input | 32 | Memory read data, same cycle |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Consumer accepts byte |
| tx_data | output | 8 | Byte out |
| tx_last | output | 1 | Final byte of the packet |
| inj_abort | input | 1 | Abort signalled during streaming |
| inj_underflow | input | 1 | Underflow signalled during streaming |
| done_irq | output | 1 | Completion pulse |
| err_irq | output | 1 | Error-stop pulse |

## Verification
The assertions check, on every cycle, the invariants of the interface. A stalled byte must stay put. A write-back never leaves the ownership bit set. The two interrupt pulses never coincide, and each pulse carries a status word that matches it. An error write switches the engine off, a byte is only offered while the engine is on, and an idle poll turns the engine on. Only the bench scenarios can show that whole chains are walked correctly. They cover the following:
- the byte order and lane selection from unaligned buffers;
- link-bit masking and interrupt suppression;
- a stop at a descriptor the engine does not own;
- malformed descriptors;
- errors injected mid-packet, with or without a handshake in the same cycle;
- address rewrites ignored while busy;
- restarts after an error stop.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W    = 32;
  localparam int CNT_W     = 11;
  localparam int OWN_BIT   = 31;
  localparam int SOP_BIT   = 21;
  localparam int EOP_BIT   = 22;
  localparam int ABT_BIT   = 8;
  localparam int UDF_BIT   = 11;
  localparam int BAD_BIT   = 12;
  localparam int QUIET_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_CTRL, ST_BUFP, ST_LINK, ST_XFER, ST_DONE
  } txd_state_e;

  function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w, input logic [1:0] lane);
    case (lane)
      2'd0:    return w[7:0];
      2'd1:    return w[15:8];
      2'd2:    return w[23:16];
      default: return w[31:24];
    endcase
  endfunction

  function automatic logic desc_malformed(input logic [CNT_W-1:0] cnt, input logic sop, input logic eop);
    return (cnt == '0) || !sop || !eop;
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic abt, input logic udf, input logic bad);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ABT_BIT] = abt;
    w[UDF_BIT] = udf;
    w[BAD_BIT] = bad;
    return w;
  endfunction
endpackage

// File: rtl/txd_desc_latch.sv
module txd_desc_latch
  import txd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_ctrl,
  input  logic              cap_bufp,
  input  logic              cap_link,
  input  logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  cnt,
  output logic              sop,
  output logic              eop,
  output logic [AW-1:0]     bufp,
  output logic [AW-1:0]     link_next,
  output logic              link_quiet
);
  logic [AW-1:1] link_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      sop        <= 1'b0;
      eop        <= 1'b0;
      bufp       <= '0;
      link_hi    <= '0;
      link_quiet <= 1'b0;
    end else begin
      if (cap_ctrl) begin
        cnt <= word[CNT_W-1:0];
        sop <= word[SOP_BIT];
        eop <= word[EOP_BIT];
      end
      if (cap_bufp) bufp <= word[AW-1:0];
      if (cap_link) begin
        link_hi    <= word[AW-1:1];
        link_quiet <= word[QUIET_BIT];
      end
    end
  end

  assign link_next = {link_hi, 1'b0};
endmodule

// File: rtl/txd_byte_path.sv
module txd_byte_path
  import txd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [AW-1:0]    bufp,
  input  logic [CNT_W-1:0] cnt,
  output logic [AW-1:0]    byte_addr,
  output logic             is_last
);
  logic [CNT_W-1:0] off;

  always_ff @(posedge clk) begin
    if (!rst_n)    off <= '0;
    else if (load) off <= '0;
    else if (adv)  off <= off + 1'b1;
  end

  assign byte_addr = bufp + AW'(off);
  assign is_last   = (off == cnt - 1'b1);
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          poll_demand,
  input  logic          cur_addr_we,
  input  logic [AW-1:0] cur_addr_wdata,
  output logic [AW-1:0] cur_addr,
  output logic          tx_on,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          inj_abort,
  input  logic          inj_underflow,
  output logic          done_irq,
  output logic          err_irq
);
  localparam logic [AW-1:0] OFS_CTRL = AW'(4);
  localparam logic [AW-1:0] OFS_BUFP = AW'(8);
  localparam logic [AW-1:0] OFS_LINK = AW'(12);

  txd_state_e state;
  logic [AW-1:0] cur_q;
  logic tx_on_q, abt_q, udf_q, bad_q;

  logic [CNT_W-1:0] cnt;
  logic sop, eop, link_quiet, is_last;
  logic [AW-1:0] bufp, link_next, byte_addr;

  // named internal events
  logic start_fetch, addr_wr_ok, desc_owned, err_in, xfer_hit, stream_end, any_err;

  txd_desc_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .cap_ctrl(state == ST_CTRL), .cap_bufp(state == ST_BUFP), .cap_link(state == ST_LINK),
    .word(mem_rdata), .cnt(cnt), .sop(sop), .eop(eop),
    .bufp(bufp), .link_next(link_next), .link_quiet(link_quiet)
  );

  txd_byte_path #(.AW(AW)) u_bytes (
    .clk(clk), .rst_n(rst_n),
    .load(state == ST_LINK), .adv(xfer_hit),
    .bufp(bufp), .cnt(cnt), .byte_addr(byte_addr), .is_last(is_last)
  );

  always_comb begin
    start_fetch = (state == ST_IDLE) && poll_demand;
    addr_wr_ok  = (state == ST_IDLE) && cur_addr_we;
    desc_owned  = mem_rdata[OWN_BIT];
    err_in      = inj_abort || inj_underflow;
    tx_valid    = (state == ST_XFER);
    xfer_hit    = tx_valid && tx_ready;
    stream_end  = tx_valid && (err_in || (tx_ready && is_last));
    any_err     = abt_q || udf_q || bad_q;
    mem_rd      = (state == ST_STAT) || (state == ST_CTRL) || (state == ST_BUFP) ||
                  (state == ST_LINK) || (state == ST_XFER);
    mem_we      = (state == ST_DONE);
    mem_wdata   = status_word(abt_q, udf_q, bad_q);
    unique case (state)
      ST_CTRL: mem_addr = cur_q + OFS_CTRL;
      ST_BUFP: mem_addr = cur_q + OFS_BUFP;
      ST_LINK: mem_addr = cur_q + OFS_LINK;
      ST_XFER: mem_addr = {byte_addr[AW-1:2], 2'b00};
      default: mem_addr = cur_q;
    endcase
    tx_data  = pick_byte(mem_rdata, byte_addr[1:0]);
    tx_last  = tx_valid && is_last;
    done_irq = mem_we && !any_err && !link_quiet;
    err_irq  = mem_we && any_err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cur_q   <= '0;
      tx_on_q <= 1'b0;
      abt_q   <= 1'b0;
      udf_q   <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (addr_wr_ok) cur_q <= cur_addr_wdata;
          if (start_fetch) begin
            tx_on_q <= 1'b1;
            abt_q   <= 1'b0;
            udf_q   <= 1'b0;
            bad_q   <= 1'b0;
            state   <= ST_STAT;
          end
        end
        ST_STAT: state <= desc_owned ? ST_CTRL : ST_IDLE;
        ST_CTRL: state <= ST_BUFP;
        ST_BUFP: state <= ST_LINK;
        ST_LINK: begin
          if (desc_malformed(cnt, sop, eop)) begin
            bad_q <= 1'b1;
            state <= ST_DONE;
          end else begin
            state <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (inj_abort)     abt_q <= 1'b1;
          if (inj_underflow) udf_q <= 1'b1;
          if (stream_end)    state <= ST_DONE;
        end
        ST_DONE: begin
          if (any_err) begin
            tx_on_q <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            cur_q <= link_next;
            state <= ST_STAT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cur_addr = cur_q;
  assign tx_on    = tx_on_q;
endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [31:0]   mem_wdata,
  input logic          inj_abort,
  input logic          inj_underflow,
  input logic          done_irq,
  input logic          err_irq,
  input logic          tx_on,
  input logic          start_fetch
);
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !inj_abort && !inj_underflow |=>
      tx_valid && $stable(tx_data) && $stable(mem_addr));

  a_r4_no_byte_during_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_we));

  a_r5_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_wdata[31]);

  a_r6_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> mem_we && (mem_wdata == 32'h0));

  a_r9_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> mem_we && (mem_wdata[12] || mem_wdata[11] || mem_wdata[8]));

  a_r9_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_irq && err_irq));

  a_r9_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !tx_on);

  a_r10_poll_enables: assert property (@(posedge clk) disable iff (!rst_n)
    start_fetch |=> tx_on);

  a_r10_stream_only_on: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_on);
endmodule

bind txd_engine txd_engine_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .inj_abort(inj_abort), .inj_underflow(inj_underflow), .done_irq(done_irq),
  .err_irq(err_irq), .tx_on(tx_on), .start_fetch(start_fetch)
);

// File: tb/test_txd_engine.sv
`timescale 1ns/1ps
module test_txd_engine;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0;
  logic poll_demand = 0, cur_addr_we = 0;
  logic [31:0] cur_addr_wdata = 0, cur_addr;
  logic tx_on, mem_rd, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_last, done_irq, err_irq;
  logic [7:0] tx_data;
  logic inj_abort = 0, inj_underflow = 0;
  logic rdy_mode = 0, rdy_low = 0;
  int   rdy_ph = 0;
  logic tx_ready;

  logic tb_we = 0;
  logic [31:0] tb_wa = 0, tb_wd = 0;
  logic [31:0] mem [0:255];

  int cmp_n = 0, bad_n = 0;
  bit finished = 0;
  logic [8:0]  exp_b[$];
  logic [65:0] exp_w[$];

  assign tx_ready  = !rdy_low && (!rdy_mode || (rdy_ph % 3 != 0));
  assign mem_rdata = mem[mem_addr[9:2]];

  txd_engine #(.AW(32)) i_txd_engine (
    .clk(clk), .rst_n(rst_n), .poll_demand(poll_demand), .cur_addr_we(cur_addr_we),
    .cur_addr_wdata(cur_addr_wdata), .cur_addr(cur_addr), .tx_on(tx_on),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .inj_abort(inj_abort), .inj_underflow(inj_underflow),
    .done_irq(done_irq), .err_irq(err_irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'h0;
    end else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    else if (tb_we)      mem[tb_wa[9:2]]    <= tb_wd;
  end

  always @(posedge clk) begin
    #1 rdy_ph = rdy_ph + 1;
  end

  function automatic logic [7:0] pat(input logic [31:0] a);
    return (a[7:0] ^ 8'hA5) + {6'b0, a[9:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    cmp_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: every accepted byte and every status write is compared in the cycle it happens
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (tx_valid && tx_ready) begin
        if (exp_b.size() == 0) chk(0, "R4 unexpected byte", {57'h0, tx_last, tx_data}, 66'h0);
        else begin
          logic [8:0] e;
          e = exp_b.pop_front();
          chk({tx_last, tx_data} == e, "R4 byte/last", {57'h0, tx_last, tx_data}, {57'h0, e});
        end
      end
      if (mem_we) begin
        logic [65:0] a;
        a = {mem_addr, mem_wdata, done_irq, err_irq};
        if (exp_w.size() == 0) chk(0, "R5 unexpected write", a, 66'h0);
        else begin
          logic [65:0] e;
          e = exp_w.pop_front();
          chk(a == e, "R5/R6/R9 status write", a, e);
        end
      end else if (done_irq || err_irq) begin
        chk(0, "R6 pulse without write", {64'h0, done_irq, err_irq}, 66'h0);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic put_word(input logic [31:0] a, input logic [31:0] d);
    tb_we = 1; tb_wa = a; tb_wd = d; step(); tb_we = 0;
  endtask

  // R3 layout: +0 status, +4 control (count 10:0, sop 21, eop 22), +8 buffer, +12 link
  task automatic put_desc(input logic [31:0] a, input bit own, input int cnt, input bit sop,
                          input bit eop, input logic [31:0] bp, input logic [31:0] lk);
    put_word(a, own ? 32'h8000_0000 : 32'h0);
    put_word(a + 4, (32'(cnt) & 32'h7FF) | (sop ? 32'h0020_0000 : 0) | (eop ? 32'h0040_0000 : 0));
    put_word(a + 8, bp);
    put_word(a + 12, lk);
  endtask

  task automatic want_bytes(input logic [31:0] bp, input int n, input bit ends);
    for (int i = 0; i < n; i++) exp_b.push_back({(ends && i == n - 1), pat(bp + 32'(i))});
  endtask

  task automatic want_write(input logic [31:0] a, input logic [31:0] d, input bit dn, input bit er);
    exp_w.push_back({a, d, dn, er});
  endtask

  task automatic set_addr(input logic [31:0] a);
    cur_addr_we = 1; cur_addr_wdata = a; step(); cur_addr_we = 0;
  endtask

  task automatic poll();
    poll_demand = 1; step(); poll_demand = 0;
  endtask

  task automatic wait_quiet();
    int q;
    q = 0;
    while (q < 3) begin
      @(negedge clk);
      if (!mem_rd && !mem_we) q++; else q = 0;
    end
    step();
  endtask

  task automatic end_checks(input string tag, input bit on, input logic [31:0] ca);
    @(negedge clk);
    chk(exp_b.size() == 0 && exp_w.size() == 0, {tag, " pending expectations"},
        66'(exp_b.size() + exp_w.size()), 66'h0);
    chk(tx_on == on, {tag, " tx_on"}, 66'(tx_on), 66'(on));
    chk(cur_addr == ca, {tag, " cur_addr"}, 66'(cur_addr), 66'(ca));
    step();
  endtask

  task automatic report();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      cmp_n++; bad_n++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_on && cur_addr == 0 && !tx_valid && !mem_rd && !mem_we && !done_irq && !err_irq,
        "R1 reset state", {32'h0, cur_addr, tx_on, tx_valid}, 66'h0);
    step();

    for (int a = 32'h200; a < 32'h400; a += 4)
      put_word(32'(a), {pat(32'(a) + 3), pat(32'(a) + 2), pat(32'(a) + 1), pat(32'(a))});

    // R2 R3 R4 R6: two-descriptor chain, unaligned buffer, quiet link bit, then unowned stop
    put_desc(32'h10, 1, 5, 1, 1, 32'h201, 32'h20);
    put_desc(32'h20, 1, 3, 1, 1, 32'h210, 32'h31);
    put_desc(32'h30, 0, 0, 0, 0, 32'h0, 32'h0);
    want_bytes(32'h201, 5, 1); want_write(32'h10, 32'h0, 1, 0);
    want_bytes(32'h210, 3, 1); want_write(32'h20, 32'h0, 0, 0);
    set_addr(32'h10); poll(); wait_quiet();
    end_checks("R2 R6 chain", 1, 32'h30);

    // R4 backpressure, R11 address write while busy ignored
    put_desc(32'h30, 1, 6, 1, 1, 32'h222, 32'h40);
    want_bytes(32'h222, 6, 1); want_write(32'h30, 32'h0, 1, 0);
    rdy_mode = 1;
    poll();
    do @(negedge clk); while (!tx_valid);
    step(); set_addr(32'h3F0);
    wait_quiet(); rdy_mode = 0;
    end_checks("R11 busy write", 1, 32'h40);

    // R7 zero count -> invalid, R9 stop
    put_desc(32'h40, 1, 0, 1, 1, 32'h240, 32'h50);
    want_write(32'h40, 32'h0000_1000, 0, 1);
    poll(); wait_quiet();
    end_checks("R7 R9 zero count", 0, 32'h40);

    // R10 restart on the failed descriptor: now unowned -> quiet idle
    poll(); wait_quiet();
    end_checks("R10 restart", 1, 32'h40);

    // R7 missing end bit
    put_desc(32'h50, 1, 4, 1, 0, 32'h250, 32'h60);
    want_write(32'h50, 32'h0000_1000, 0, 1);
    set_addr(32'h50); poll(); wait_quiet();
    end_checks("R7 no eop", 0, 32'h50);

    // R8 abort in the cycle of the third byte (accepted)
    put_desc(32'h60, 1, 8, 1, 1, 32'h260, 32'h70);
    want_bytes(32'h260, 3, 0); want_write(32'h60, 32'h0000_0100, 0, 1);
    set_addr(32'h60); poll();
    do @(negedge clk); while (!tx_valid);
    @(posedge clk); @(posedge clk); #1;
    inj_abort = 1; step(); inj_abort = 0;
    wait_quiet();
    end_checks("R8 R9 abort", 0, 32'h60);

    // R8 underflow and abort together while stalled: no byte moves
    put_desc(32'h70, 1, 4, 1, 1, 32'h281, 32'h80);
    want_write(32'h70, 32'h0000_0900, 0, 1);
    rdy_low = 1;
    set_addr(32'h70); poll();
    do @(negedge clk); while (!tx_valid);
    inj_abort = 1; inj_underflow = 1;
    step(); inj_abort = 0; inj_underflow = 0; rdy_low = 0;
    wait_quiet();
    end_checks("R8 underflow", 0, 32'h70);

    report();
  end
endmodule